// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Single-Edge Interrupts

This block is a register-mapped general-purpose I/O controller. Its pins are grouped into ports of eight, and there can be up to seven ports. Each port has its own register window and its own interrupt line. All ports share one global control word. For each pin, software sets a two-bit drive mode, an output data bit and a pull-up disable bit, and can read back the pin level after synchronisation. The block turns these settings into three pad controls per pin: output value, output enable and pull enable.

Each pin has an edge detector that watches one edge only, rising or falling, chosen by a per-pin bit. A detected edge sets a sticky event bit, and software clears it by writing a one to it. A per-pin enable selects which events reach the port's interrupt line. A test-force bit sets an event without any change on the pin. A global clock-request bit works as the master switch for event capture.

The register bus is a plain 32-bit interface. A write takes effect at the clock edge where the write strobe is seen. Read data is combinational from the address.

Top module: `mpgpio_ctrl`

## Requirements
- R1: Port p occupies the byte window starting at p×0x30. Inside a window the registers sit at these offsets: level 0x04, output data 0x08, drive mode 0x0C, pull-up disable 0x10, event 0x14, interrupt enable 0x18, force 0x1C, edge select 0x20. Any other address reads 0, including offset 0x00 of ports other than port 0 and addresses past the last port.
- R2: Address 0x00 holds the global control word. Bits [1:0] are read/write, with bit 0 being clock-request enable and bit 1 being sync select. Bits [8:2] return the version parameter and bits [15:9] return the port count. Both of these fields are read-only. All other bits read 0.
- R3: The level register returns the pad inputs after a two-flop synchroniser, so a pin change is visible on the second rising clock edge after it. Writes to the level register have no effect.
- R4: The drive mode uses bits [2n+1:2n] for pin n. The codes are: 0 = input, where output enable is never asserted; 1 = push-pull, where output enable is always asserted; 2 = open-drain, where output enable is asserted when the data bit is 0; 3 = open-source, where output enable is asserted when the data bit is 1. pad_out always carries the data bit. Only the low 16 bits of the mode register are stored.
- R5: Bit n of the pull-up register set to 1 turns off the pull on pin n, so pad_pull_en is the inverse of that bit. Only the low 8 bits are stored.
- R6: Edge-select bit n = 0 detects a falling edge and 1 detects a rising edge. A matching edge sets event bit n one cycle after the synchronised level changes. The opposite edge sets nothing.
- R7: Event bits are sticky. Writing 1 clears a bit and writing 0 leaves it unchanged. A set from an edge or a force in the same cycle wins over the clear.
- R8: The interrupt line of port p is high exactly when some pin of that port has both its event bit and its enable bit set. Each port's line is independent of the other ports.
- R9: While a force bit is 1, its event bit is set every cycle whatever the pin level. Writing 0 stops forcing.
- R10: While control bit 0 is 0, no edge and no force sets an event. Edges that happen during this time are not reported after the bit is set again. Register writes and pad outputs keep working.
- R11: Reset clears every writable register. After reset all outputs are disabled, all pulls are enabled and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (read when low) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pad_in | input | 8×NUM_PORTS | Raw pad levels |
| pad_out | output | 8×NUM_PORTS | Output value per pin |
| pad_oe | output | 8×NUM_PORTS | Output enable per pin |
| pad_pull_en | output | 8×NUM_PORTS | Pull-up enable per pin |
| irq | output | NUM_PORTS | Interrupt line per port |

## Verification
Register and pad-control results are due on the first falling clock edge after the rising edge that captured the write. A pin change shows up in the level register two rising edges later. The event bit, and with it the interrupt line, follows one edge after that. The bench changes pins at a falling edge and then reads at the falling edges after the first, second and third rising edges, so both the early absence and the arrival of each result are checked. Every expected value goes into the scoreboard at the moment the driver drives the access, and the monitor compares it 1 ns later, well clear of any rising edge.

// File: rtl/mpgpio_pkg.sv
package mpgpio_pkg;
    localparam int PINS   = 8;
    localparam int STRIDE = 48;
    localparam int OFS_W  = 6;

    localparam logic [OFS_W-1:0] OFS_LEVEL = 6'h04;
    localparam logic [OFS_W-1:0] OFS_DATA  = 6'h08;
    localparam logic [OFS_W-1:0] OFS_MODE  = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_PULL  = 6'h10;
    localparam logic [OFS_W-1:0] OFS_EVT   = 6'h14;
    localparam logic [OFS_W-1:0] OFS_IEN   = 6'h18;
    localparam logic [OFS_W-1:0] OFS_FORCE = 6'h1C;
    localparam logic [OFS_W-1:0] OFS_EDGE  = 6'h20;

    typedef enum logic [1:0] {
        DRV_INPUT     = 2'd0,
        DRV_PUSHPULL  = 2'd1,
        DRV_OPENDRAIN = 2'd2,
        DRV_OPENSRC   = 2'd3
    } drive_mode_e;

    typedef struct packed {
        logic [PINS-1:0]   data;
        logic [2*PINS-1:0] mode;
        logic [PINS-1:0]   pull_off;
        logic [PINS-1:0]   evt;
        logic [PINS-1:0]   ien;
        logic [PINS-1:0]   force_set;
        logic [PINS-1:0]   rise_sel;
        logic [PINS-1:0]   prev;
    } port_state_t;
endpackage

// File: rtl/mpgpio_sync.sv
module mpgpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = raw_i;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/mpgpio_port.sv
module mpgpio_port
    import mpgpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              sel,
    input  logic              wr,
    input  logic [OFS_W-1:0]  off,
    input  logic [2*PINS-1:0] wdata,
    output logic [31:0]       rdata,
    input  logic [PINS-1:0]   pin_raw,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_pull_en,
    output logic              irq
);
    port_state_t     st_d, st_q;
    logic [PINS-1:0] lvl;
    logic [PINS-1:0] edge_hit;
    logic            wr_go;

    mpgpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_raw),
        .sync_o (lvl)
    );

    assign wr_go = sel && wr;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < PINS; i++)
            edge_hit[i] = st_q.rise_sel[i] ? (lvl[i] & ~st_q.prev[i])
                                           : (~lvl[i] & st_q.prev[i]);
        if (wr_go) begin
            case (off)
                OFS_DATA:  st_d.data      = wdata[PINS-1:0];
                OFS_MODE:  st_d.mode      = wdata;
                OFS_PULL:  st_d.pull_off  = wdata[PINS-1:0];
                OFS_EVT:   st_d.evt       = st_q.evt & ~wdata[PINS-1:0];
                OFS_IEN:   st_d.ien       = wdata[PINS-1:0];
                OFS_FORCE: st_d.force_set = wdata[PINS-1:0];
                OFS_EDGE:  st_d.rise_sel  = wdata[PINS-1:0];
                default: ;
            endcase
        end
        st_d.prev = lvl;
        if (cap_en) st_d.evt = st_d.evt | edge_hit | st_q.force_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < PINS; i++) begin
            case (drive_mode_e'(st_q.mode[2*i +: 2]))
                DRV_PUSHPULL:  pin_oe[i] = 1'b1;
                DRV_OPENDRAIN: pin_oe[i] = ~st_q.data[i];
                DRV_OPENSRC:   pin_oe[i] = st_q.data[i];
                default:       pin_oe[i] = 1'b0;
            endcase
        end
    end

    assign pin_out     = st_q.data;
    assign pin_pull_en = ~st_q.pull_off;
    assign irq         = |(st_q.evt & st_q.ien);

    always_comb begin
        case (off)
            OFS_LEVEL: rdata = 32'(lvl);
            OFS_DATA:  rdata = 32'(st_q.data);
            OFS_MODE:  rdata = 32'(st_q.mode);
            OFS_PULL:  rdata = 32'(st_q.pull_off);
            OFS_EVT:   rdata = 32'(st_q.evt);
            OFS_IEN:   rdata = 32'(st_q.ien);
            OFS_FORCE: rdata = 32'(st_q.force_set);
            OFS_EDGE:  rdata = 32'(st_q.rise_sel);
            default:   rdata = 32'h0;
        endcase
    end

    // R7: a set event bit survives unless a write-1-clear hit it
    a_r7_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.evt) & ~($past(wr_go && off == OFS_EVT) ? $past(wdata[PINS-1:0]) : '0)
                   & ~st_q.evt) == '0));

    // R9: a force bit produces its event on the next edge while capture is on
    a_r9_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && (st_q.force_set != '0)) |=> ((st_q.evt & $past(st_q.force_set)) == $past(st_q.force_set)));

    // R10: with capture off no event bit can rise
    a_r10_capture_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ((st_q.evt & ~$past(st_q.evt)) == '0));

    // R4: an all-input mode write leaves every pin undriven
    a_r4_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && off == OFS_MODE && wdata == '0) |=> (pin_oe == '0));
endmodule

// File: rtl/mpgpio_ctrl.sv
module mpgpio_ctrl
    import mpgpio_pkg::*;
#(
    parameter int NUM_PORTS  = 7,
    parameter int VERSION_ID = 3,
    parameter int ADDR_W     = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_PORTS*PINS-1:0] pad_in,
    output logic [NUM_PORTS*PINS-1:0] pad_out,
    output logic [NUM_PORTS*PINS-1:0] pad_oe,
    output logic [NUM_PORTS*PINS-1:0] pad_pull_en,
    output logic [NUM_PORTS-1:0]      irq
);
    localparam logic [6:0] VER_FIELD  = 7'(VERSION_ID);
    localparam logic [6:0] CORE_FIELD = 7'(NUM_PORTS);

    logic [1:0]                 ctrl_d, ctrl_q;
    logic                       ctrl_hit;
    logic [NUM_PORTS-1:0]       win_hit;
    logic [NUM_PORTS-1:0][31:0] port_rd;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] rel_addr;
    logic                       unused_bits;

    assign ctrl_hit = (bus_addr == '0);

    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_sel && bus_wr && ctrl_hit) ctrl_d = bus_wdata[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(p * STRIDE);
        localparam logic [ADDR_W:0] HI = (ADDR_W+1)'((p + 1) * STRIDE);

        assign win_hit[p]  = ({1'b0, bus_addr} >= LO) && ({1'b0, bus_addr} < HI);
        assign rel_addr[p] = bus_addr - LO[ADDR_W-1:0];

        mpgpio_port port_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .cap_en      (ctrl_q[0]),
            .sel         (bus_sel && win_hit[p]),
            .wr          (bus_wr),
            .off         (rel_addr[p][OFS_W-1:0]),
            .wdata       (bus_wdata[2*PINS-1:0]),
            .rdata       (port_rd[p]),
            .pin_raw     (pad_in[p*PINS +: PINS]),
            .pin_out     (pad_out[p*PINS +: PINS]),
            .pin_oe      (pad_oe[p*PINS +: PINS]),
            .pin_pull_en (pad_pull_en[p*PINS +: PINS]),
            .irq         (irq[p])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit) bus_rdata = {16'h0, CORE_FIELD, VER_FIELD, ctrl_q};
        for (int p = 0; p < NUM_PORTS; p++)
            if (win_hit[p]) bus_rdata = bus_rdata | port_rd[p];
    end

    assign unused_bits = ^{bus_wdata[31:2*PINS], rel_addr, ctrl_q[1]};
endmodule

// File: tb/mpgpio_ctrl_tb_top.sv
`timescale 1ns/1ps
module mpgpio_ctrl_tb_top;
    localparam int NP   = 7;
    localparam int VER  = 3;
    localparam int AW   = 9;
    localparam int NPIN = NP * 8;

    typedef enum int {K_RD, K_OE, K_OUT, K_PULL, K_IRQ} kind_e;
    typedef struct {
        kind_e       kind;
        logic [63:0] exp;
        string       tag;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NPIN-1:0] pad_in = '0;
    logic [NPIN-1:0] pad_out, pad_oe, pad_pull_en;
    logic [NP-1:0]   irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    mpgpio_ctrl #(.NUM_PORTS(NP), .VERSION_ID(VER), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .irq(irq)
    );

    task automatic push(kind_e k, logic [63:0] e, string t);
        item_t it;
        it.kind = k; it.exp = e; it.tag = t;
        sb_q.push_back(it);
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic rd(int a, logic [31:0] e, string t);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
        push(K_RD, 64'(e), t);
    endtask

    task automatic chk(kind_e k, logic [63:0] e, string t);
        @(negedge clk);
        push(k, e, t);
    endtask

    task automatic set_pin(int idx, logic v);
        @(negedge clk);
        pad_in[idx] = v;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the scoreboard 1 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RD:    act = 64'(bus_rdata);
                    K_OE:    act = 64'(pad_oe);
                    K_OUT:   act = 64'(pad_out);
                    K_PULL:  act = 64'(pad_pull_en);
                    default: act = 64'(irq);
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [31:0] RO = 32'((NP << 9) | (VER << 2));

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R11 / R2 reset state
        rd(32'h000, RO, "R2 R11 ctrl reset");
        rd(32'h00C, 32'h0, "R11 mode reset");
        chk(K_OE, 64'h0, "R11 oe reset");
        chk(K_OUT, 64'h0, "R11 out reset");
        chk(K_PULL, 64'(56'hFF_FFFF_FFFF_FFFF), "R11 pull reset");
        chk(K_IRQ, 64'h0, "R11 irq reset");
        // R2 control word
        wr(32'h000, 32'hFFFF_FFFF);
        rd(32'h000, RO | 32'h3, "R2 ctrl rw bits");
        wr(32'h000, 32'h1);
        rd(32'h000, RO | 32'h1, "R2 ctrl enable");
        // R4 drive modes on port 1
        wr(32'h03C, 32'hFFFF_00E4);
        rd(32'h03C, 32'h0000_00E4, "R4 mode low 16 bits");
        chk(K_OE, 64'h0600, "R4 oe with data 0");
        wr(32'h038, 32'hFF);
        chk(K_OE, 64'h0A00, "R4 oe with data 1");
        chk(K_OUT, 64'hFF00, "R4 pad_out follows data");
        // R5 pull control on port 2
        wr(32'h070, 32'h1A5);
        rd(32'h070, 32'hA5, "R5 pull low 8 bits");
        chk(K_PULL, 64'(56'hFF_FFFF_FF5A_FFFF), "R5 pull enable inverse");
        // R3 level readback on port 3
        @(negedge clk);
        pad_in[31:24] = 8'h3C;
        rd(32'h094, 32'h00, "R3 level after one edge");
        rd(32'h094, 32'h3C, "R3 level after two edges");
        wr(32'h094, 32'hFF);
        rd(32'h094, 32'h3C, "R3 level write ignored");
        // R6 falling edge on port 0 pin 2
        wr(32'h018, 32'h04);
        set_pin(2, 1'b1);
        idle(3);
        rd(32'h014, 32'h00, "R6 opposite edge ignored");
        set_pin(2, 1'b0);
        rd(32'h004, 32'h04, "R3 old level still seen");
        rd(32'h014, 32'h00, "R6 event not yet set");
        rd(32'h014, 32'h04, "R6 falling event set");
        chk(K_IRQ, 64'h01, "R8 irq port 0 only");
        // R7 write-1-clear
        wr(32'h014, 32'h00);
        rd(32'h014, 32'h04, "R7 write zero keeps event");
        wr(32'h014, 32'h04);
        rd(32'h014, 32'h00, "R7 write one clears");
        chk(K_IRQ, 64'h0, "R8 irq drops after clear");
        // R6 rising edge on pin 3, R8 enable gating
        wr(32'h020, 32'h08);
        set_pin(3, 1'b1);
        idle(2);
        rd(32'h014, 32'h08, "R6 rising event set");
        chk(K_IRQ, 64'h0, "R8 disabled event no irq");
        wr(32'h018, 32'h0C);
        chk(K_IRQ, 64'h01, "R8 enabled event irq");
        wr(32'h014, 32'h08);
        chk(K_IRQ, 64'h0, "R8 irq cleared");
        // R9 force on port 5
        wr(32'h10C, 32'h81);
        rd(32'h104, 32'h81, "R9 force sets event");
        wr(32'h104, 32'h81);
        rd(32'h104, 32'h81, "R7 set wins over clear");
        wr(32'h10C, 32'h00);
        wr(32'h104, 32'h81);
        rd(32'h104, 32'h00, "R9 force off then clear");
        // R10 capture disabled
        wr(32'h000, 32'h0);
        wr(32'h10C, 32'h01);
        idle(2);
        rd(32'h104, 32'h00, "R10 force ignored when off");
        set_pin(2, 1'b1);
        idle(3);
        set_pin(2, 1'b0);
        idle(4);
        rd(32'h014, 32'h00, "R10 edge ignored when off");
        wr(32'h10C, 32'h00);
        wr(32'h000, 32'h1);
        idle(4);
        rd(32'h014, 32'h00, "R10 no stale edge after enable");
        rd(32'h104, 32'h00, "R10 no stale force after enable");
        // R1 window decode
        wr(32'h138, 32'h5A);
        rd(32'h138, 32'h5A, "R1 port 6 window");
        rd(32'h018, 32'h0C, "R1 port 0 untouched");
        rd(32'h024, 32'h0, "R1 unmapped offset");
        rd(32'h030, 32'h0, "R1 port 1 offset zero");
        rd(32'h150, 32'h0, "R1 beyond last port");
        idle(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule